// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Master

This block is a register-mapped serial master for a host processor. The host writes a word into a transmit holding register. As soon as the shifter is free, the word moves into the shifter. The word then leaves on the data-out line, most significant bit first, while the same number of bits from the data-in line is collected into a receive holding register. A divider register sets the serial clock rate. A control register chooses the clock polarity, the clock phase and a word length of 8 or 16 bits.

The chip-select pin is controlled only by software, through a select register. The host lowers it before a word and raises it afterwards. The slave acts on a word when the select line rises. An interrupt request signals that the transmit holding register can take another word, so one word can wait while the previous one is still shifting. A status register reports the following:
- whether the transmit holding register is empty
- whether a word is in progress
- whether the receive holding register is full
- a sticky overrun bit, cleared by writing 1
- a sticky completion bit, cleared by writing 1

The transfer engine is a state machine with five states:
- `ST_IDLE` waits for a held word.
- `ST_LEAD` waits for the leading clock edge. It enters from `ST_IDLE` when a word is loaded, and from `ST_TRAIL` while bits remain.
- `ST_TRAIL` waits for the trailing clock edge.
- `ST_TAIL` holds the clock at its idle level for one half period after the last bit. It enters from `ST_TRAIL` on the last bit.
- `ST_DONE` lasts one cycle and delivers the received word, then always returns to `ST_IDLE`.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, the status register (address 3) reads 0x0001, `spi_ss_n` is 1, `spi_sclk` is 0 and `irq` is 0.
- R2: Each serial clock half period lasts N system cycles. N is the divider register (address 0), except that values 0 and 1 give N = 2.
- R3: The control register is at address 1 and has these bits:
  - bit0: enable
  - bit1: master
  - bit2: CPOL
  - bit3: CPHA
  - bit4: wide (1 = 16-bit words, 0 = 8-bit words)
  
  A held word does not start while enable or master is 0. It starts once both are 1.
- R4: The select register is at address 2. Bit0 gives the pin to chip select and bit1 is its level. `spi_ss_n` equals bit1 when bit0 is 1, and is 1 otherwise.
- R5: A write to address 4 places a word in the transmit holding register and clears status bit0. On the next cycle, if the shifter is idle and enabled, the word moves to the shifter and bit0 returns to 1. `irq` equals enable AND status bit0, and is 0 in the cycle after a write to address 4.
- R6: Bits leave `spi_mosi` most significant bit first. The serial clock idles at CPOL. With CPHA = 0, data is sampled on leading edges and changed on trailing edges. With CPHA = 1, data is changed on leading edges and sampled on trailing edges. An 8-bit word sends the low byte of the written value.
- R7: At the end of a word, the received bits go to the receive holding register (address 5) and status bit2 is set. An 8-bit word is zero-extended. A read of address 5 with `bus_re` clears bit2.
- R8: If status bit2 is still set when a word completes, status bit3 (overrun) is set and the new word replaces the old one.
- R9: Status bit1 (busy) does not change in the cycle after the buffer write. It rises one cycle later and falls after the word completes, when sticky status bit4 is also set.
- R10: Writing 1 to status bit3 or bit4 clears that bit. Writing 0 leaves it unchanged.
- R11: A word written while another is shifting is held, with status bit0 at 0. It starts by itself after the current word ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_we | input | 1 | register write strobe |
| bus_re | input | 1 | register read strobe (side effect on address 5 only) |
| bus_addr | input | 3 | register address |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data for `bus_addr` |
| irq | output | 1 | transmit holding register can accept a word |
| spi_sclk | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data out |
| spi_miso | input | 1 | serial data in |
| spi_ss_n | output | 1 | software-driven chip select |

## Verification
The bench uses the default parameters:
- 16-bit data
- an 8-bit short word
- a 16-bit divider

Under these parameters both word lengths and all four clock modes are reachable, from one configuration. The divider values are a clamped 0, small odd and even values, and 0x100. This set covers the clamp and the half-period timing without long runs. A model slave on the bench sees the bits the block sends and supplies reply words, including back-to-back replies for the held-word and overrun cases.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_TAIL,
        ST_DONE
    } xfer_state_e;

    localparam int REG_AW = 3;

    // register addresses
    localparam logic [REG_AW-1:0] A_BAUD = 3'd0;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] A_SEL  = 3'd2;
    localparam logic [REG_AW-1:0] A_STAT = 3'd3;
    localparam logic [REG_AW-1:0] A_TXB  = 3'd4;
    localparam logic [REG_AW-1:0] A_RXB  = 3'd5;

    // control bits
    localparam int C_EN   = 0;
    localparam int C_MST  = 1;
    localparam int C_CPOL = 2;
    localparam int C_CPHA = 3;
    localparam int C_WIDE = 4;

    // status bits
    localparam int S_TXE  = 0;
    localparam int S_BUSY = 1;
    localparam int S_RXF  = 2;
    localparam int S_OVR  = 3;
    localparam int S_DONE = 4;

    // select bits
    localparam int F_SELEN = 0;
    localparam int F_LVL   = 1;

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] baud,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);
    localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt_q;

    assign half = (baud < MIN_HALF) ? MIN_HALF : baud;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= half - ONE;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? (half - ONE) : (cnt_q - ONE);
        end
    end

    assign tick = run && !restart && (cnt_q == '0);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_master_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word_in,
    input  logic              wide,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int PAD_W = DATA_W - SHORT_W;
    localparam logic [CNT_W-1:0] FULL_BITS  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] SHORT_BITS = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] ONE_BIT    = CNT_W'(1);

    xfer_state_e state_q, state_d;

    logic [DATA_W-1:0] sreg_q;
    logic [DATA_W-1:0] rreg_q;
    logic [CNT_W-1:0]  left_q;
    logic              sclk_q;
    logic              first_q;
    logic              wide_q;
    logic              cpha_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)  state_d = (left_q == ONE_BIT) ? ST_TAIL : ST_LEAD;
            ST_TAIL:  if (tick)  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and serial outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q  <= '0;
            rreg_q  <= '0;
            left_q  <= '0;
            sclk_q  <= 1'b0;
            first_q <= 1'b0;
            wide_q  <= 1'b0;
            cpha_q  <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            sreg_q  <= wide ? word_in : {word_in[SHORT_W-1:0], {PAD_W{1'b0}}};
            rreg_q  <= '0;
            left_q  <= wide ? FULL_BITS : SHORT_BITS;
            sclk_q  <= cpol;
            first_q <= 1'b1;
            wide_q  <= wide;
            cpha_q  <= cpha;
        end else if (state_q == ST_LEAD && tick) begin
            sclk_q  <= ~sclk_q;
            first_q <= 1'b0;
            if (!cpha_q)       rreg_q <= {rreg_q[DATA_W-2:0], miso};
            else if (!first_q) sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
        end else if (state_q == ST_TRAIL && tick) begin
            sclk_q <= ~sclk_q;
            left_q <= left_q - ONE_BIT;
            if (cpha_q) rreg_q <= {rreg_q[DATA_W-2:0], miso};
            else        sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign mosi    = sreg_q[DATA_W-1];
    assign sclk    = busy ? sclk_q : cpol;
    assign rx_word = wide_q ? rreg_q : {{PAD_W{1'b0}}, rreg_q[SHORT_W-1:0]};

endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
    import spi_master_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHORT_W = 8,
    parameter int DIV_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_ss_n
);
    logic [DIV_W-1:0]  baud_q;
    logic              en_q, mst_q, cpol_q, cpha_q, wide_q;
    logic              selen_q, lvl_q;
    logic [DATA_W-1:0] tx_buf_q;
    logic              tx_full_q;
    logic [DATA_W-1:0] rx_buf_q;
    logic              rx_full_q;
    logic              ovr_q;
    logic              done_q;

    logic              xfer_busy;
    logic              xfer_done;
    logic              xfer_start;
    logic              tick;
    logic [DATA_W-1:0] rx_word;

    logic wr_baud, wr_ctrl, wr_sel, wr_stat, wr_tx, rd_rx;

    assign wr_baud = bus_we && (bus_addr == A_BAUD);
    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_sel  = bus_we && (bus_addr == A_SEL);
    assign wr_stat = bus_we && (bus_addr == A_STAT);
    assign wr_tx   = bus_we && (bus_addr == A_TXB);
    assign rd_rx   = bus_re && (bus_addr == A_RXB);

    assign xfer_start = tx_full_q && !xfer_busy && en_q && mst_q;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_q  <= '0;
            en_q    <= 1'b0;
            mst_q   <= 1'b0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            wide_q  <= 1'b0;
            selen_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else begin
            if (wr_baud) baud_q <= bus_wdata[DIV_W-1:0];
            if (wr_ctrl) begin
                en_q   <= bus_wdata[C_EN];
                mst_q  <= bus_wdata[C_MST];
                cpol_q <= bus_wdata[C_CPOL];
                cpha_q <= bus_wdata[C_CPHA];
                wide_q <= bus_wdata[C_WIDE];
            end
            if (wr_sel) begin
                selen_q <= bus_wdata[F_SELEN];
                lvl_q   <= bus_wdata[F_LVL];
            end
        end
    end

    // transmit holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf_q  <= '0;
            tx_full_q <= 1'b0;
        end else if (wr_tx) begin
            tx_buf_q  <= bus_wdata;
            tx_full_q <= 1'b1;
        end else if (xfer_start) begin
            tx_full_q <= 1'b0;
        end
    end

    // receive side and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf_q  <= '0;
            rx_full_q <= 1'b0;
            ovr_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (xfer_done) begin
                rx_buf_q  <= rx_word;
                rx_full_q <= 1'b1;
            end else if (rd_rx) begin
                rx_full_q <= 1'b0;
            end
            if (xfer_done && rx_full_q)          ovr_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_OVR]) ovr_q <= 1'b0;
            if (xfer_done)                        done_q <= 1'b1;
            else if (wr_stat && bus_wdata[S_DONE]) done_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_BAUD: bus_rdata[DIV_W-1:0] = baud_q;
            A_CTRL: begin
                bus_rdata[C_EN]   = en_q;
                bus_rdata[C_MST]  = mst_q;
                bus_rdata[C_CPOL] = cpol_q;
                bus_rdata[C_CPHA] = cpha_q;
                bus_rdata[C_WIDE] = wide_q;
            end
            A_SEL: begin
                bus_rdata[F_SELEN] = selen_q;
                bus_rdata[F_LVL]   = lvl_q;
            end
            A_STAT: begin
                bus_rdata[S_TXE]  = !tx_full_q;
                bus_rdata[S_BUSY] = xfer_busy;
                bus_rdata[S_RXF]  = rx_full_q;
                bus_rdata[S_OVR]  = ovr_q;
                bus_rdata[S_DONE] = done_q;
            end
            A_TXB:   bus_rdata = tx_buf_q;
            A_RXB:   bus_rdata = rx_buf_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq      = en_q && !tx_full_q;
    assign spi_ss_n = selen_q ? lvl_q : 1'b1;

    spi_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (xfer_start),
        .run     (xfer_busy),
        .baud    (baud_q),
        .tick    (tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .word_in (tx_buf_q),
        .wide    (wide_q),
        .cpol    (cpol_q),
        .cpha    (cpha_q),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (xfer_busy),
        .done    (xfer_done),
        .rx_word (rx_word),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

endmodule

// File: rtl/spi_master_ctrl_chk.sv
module spi_master_ctrl_chk
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              busy,
    input logic              done,
    input logic              rx_full,
    input logic              ovr
);
    // R5: a buffer write drops the interrupt on the next cycle
    a_r5_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_TXB) |=> !irq);

    // R9: busy does not rise in the cycle right after the buffer write
    a_r9_busy_lags_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_TXB && !busy && irq) |=> !busy);

    // R7: a completed word leaves the receive buffer full
    a_r7_done_fills_rx: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);

    // R8: completion onto a full receive buffer flags overrun
    a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full) |=> ovr);

    // R10: writing 0 to the overrun bit keeps it
    a_r10_w1c_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STAT && !bus_wdata[S_OVR] && ovr) |=> ovr);

endmodule

bind spi_master_ctrl spi_master_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .busy      (xfer_busy),
    .done      (xfer_done),
    .rx_full   (rx_full_q),
    .ovr       (ovr_q)
);

// File: tb/spi_master_ctrl_tb.sv
`timescale 1ns/1ps
module spi_master_ctrl_tb_top;

    localparam int VW = 51;
    localparam int NV = 6;
    // {wide, cpol, cpha, baud[15:0], tx[15:0], reply[15:0]}
    localparam logic [VW-1:0] VECS [0:NV-1] = '{
        {1'b1, 1'b0, 1'b0, 16'd2,     16'hA53C, 16'h3CC3},
        {1'b1, 1'b1, 1'b0, 16'd3,     16'hFF0A, 16'h1234},
        {1'b1, 1'b0, 1'b1, 16'd2,     16'h0F0F, 16'h8001},
        {1'b1, 1'b1, 1'b1, 16'd4,     16'h8421, 16'hFEDC},
        {1'b0, 1'b0, 1'b0, 16'd2,     16'h125A, 16'h77C5},
        {1'b0, 1'b1, 1'b1, 16'h0100,  16'h00A7, 16'h0093}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, spi_sclk, spi_mosi, spi_miso, spi_ss_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_master_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
    );

    // ---------------- model slave ----------------
    logic        arm_cpol = 0, arm_cpha = 0, arm_wide = 1;
    logic [15:0] arm_reply = '0, arm_next = '0;
    logic [15:0] s_out = '0, s_in = '0, s_next = '0, s_last = '0;
    int          s_cnt = 0;
    bit          s_first = 1, s_was_high = 1;
    logic        s_prev = 0;
    bit          s_lead, s_sample;

    assign spi_miso = s_out[arm_wide ? 15 : 7];

    always @(spi_sclk or spi_ss_n) begin
        if (spi_ss_n) begin
            s_was_high = 1;
        end else if (s_was_high) begin
            s_was_high = 0;
            s_out = arm_reply; s_next = arm_next;
            s_cnt = 0; s_first = 1; s_in = '0; s_prev = spi_sclk;
        end else if (spi_sclk != s_prev) begin
            s_prev   = spi_sclk;
            s_lead   = (spi_sclk != arm_cpol);
            s_sample = arm_cpha ? !s_lead : s_lead;
            if (s_sample) begin
                s_in = {s_in[14:0], spi_mosi};
                s_cnt++;
                if (arm_cpha && s_cnt == (arm_wide ? 16 : 8)) begin
                    s_last = s_in; s_out = s_next; s_cnt = 0; s_first = 1; s_in = '0;
                end
            end else if (!arm_cpha) begin
                if (s_cnt == (arm_wide ? 16 : 8)) begin
                    s_last = s_in; s_out = s_next; s_cnt = 0; s_in = '0;
                end else begin
                    s_out = s_out << 1;
                end
            end else begin
                if (s_first) s_first = 0;
                else         s_out = s_out << 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // tasks begin and end at a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_re = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 0;
    endtask

    task automatic wait_done();
        logic [15:0] st;
        for (int i = 0; i < 40000; i++) begin
            bus_read(3'd3, st);
            if (st[4] && !st[1]) break;
        end
    endtask

    task automatic run_vec(input logic [VW-1:0] v, input int idx);
        logic [15:0] st, rx, exp_tx, exp_rx;
        logic w, cp, ch;
        w = v[50]; cp = v[49]; ch = v[48];
        exp_tx = w ? v[31:16] : {8'h00, v[23:16]};
        exp_rx = w ? v[15:0]  : {8'h00, v[7:0]};
        bus_write(3'd0, v[47:32]);
        bus_write(3'd1, {11'd0, w, ch, cp, 2'b11});
        arm_cpol = cp; arm_cpha = ch; arm_wide = w;
        arm_reply = v[15:0]; arm_next = 16'h0000;
        bus_write(3'd2, 16'h0001);
        check($sformatf("R4 ss low vec%0d", idx), spi_ss_n, 1'b0);
        bus_write(3'd4, v[31:16]);
        wait_done();
        bus_write(3'd2, 16'h0003);
        check($sformatf("R4 ss high vec%0d", idx), spi_ss_n, 1'b1);
        check($sformatf("R6 sclk idle at cpol vec%0d", idx), spi_sclk, cp);
        check($sformatf("R6 slave got word vec%0d", idx), s_last & (w ? 16'hFFFF : 16'h00FF), exp_tx);
        bus_read(3'd3, st);
        check($sformatf("R7 rxf set vec%0d", idx), st[2], 1'b1);
        bus_read(3'd5, rx);
        check($sformatf("R7 rx word vec%0d", idx), rx, exp_rx);
        bus_read(3'd3, st);
        check($sformatf("R7 rxf cleared vec%0d", idx), st[2], 1'b0);
        bus_write(3'd3, 16'h0018);
    endtask

    task automatic measure_half(input logic [15:0] baud, input int exp_half);
        int n;
        n = 0;
        bus_write(3'd0, baud);
        bus_write(3'd1, 16'h0013);
        bus_write(3'd4, 16'hAAAA);
        for (int i = 0; i < 100 && spi_sclk == 1'b0; i++) @(negedge clk);
        while (spi_sclk == 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check($sformatf("R2 half period baud=%0d", baud), n, exp_half);
        wait_done();
        bus_write(3'd3, 16'h0018);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        logic [15:0] st, rx;
        #1;
        check("R1 ss_n at reset", spi_ss_n, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        bus_read(3'd3, st);
        check("R1 status reset value", st, 16'h0001);
        check("R1 sclk reset", spi_sclk, 1'b0);
        check("R1 irq reset", irq, 1'b0);

        // vector table over modes and widths (R6, R7)
        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R4: level ignored while select is not enabled
        bus_write(3'd2, 16'h0000);
        check("R4 disabled select stays high", spi_ss_n, 1'b1);

        // R2: divider clamp and plain values
        measure_half(16'd0, 2);
        measure_half(16'd1, 2);
        measure_half(16'd5, 5);

        // R3: no start without master bit
        bus_write(3'd1, 16'h0011);
        bus_write(3'd4, 16'h1111);
        repeat (20) @(negedge clk);
        bus_read(3'd3, st);
        check("R3 held without master: busy", st[1], 1'b0);
        check("R3 held without master: txe", st[0], 1'b0);
        bus_write(3'd1, 16'h0013);
        wait_done();
        bus_read(3'd3, st);
        check("R3 runs once master set", st[4], 1'b1);
        bus_read(3'd5, rx);
        bus_write(3'd3, 16'h0018);

        // R5, R9: timing of the buffer hand-off and busy
        bus_write(3'd0, 16'd2);
        bus_write(3'd1, 16'h0013);
        check("R5 irq when empty and enabled", irq, 1'b1);
        bus_write(3'd4, 16'h2222);
        check("R5 irq cleared by write", irq, 1'b0);
        bus_read(3'd3, st);
        check("R9 busy unchanged after write", st[1], 1'b0);
        check("R5 txe low after write", st[0], 1'b0);
        bus_read(3'd3, st);
        check("R9 busy one cycle later", st[1], 1'b1);
        check("R5 txe back after move", st[0], 1'b1);
        check("R5 irq back after move", irq, 1'b1);
        wait_done();
        bus_read(3'd3, st);
        check("R9 busy falls at end", st[1], 1'b0);
        check("R9 done sticky set", st[4], 1'b1);
        bus_read(3'd5, rx);
        bus_write(3'd3, 16'h0018);

        // R11 and R8: held second word, no read between words
        arm_cpol = 0; arm_cpha = 0; arm_wide = 1;
        arm_reply = 16'hC001; arm_next = 16'h5A5A;
        bus_write(3'd2, 16'h0001);
        bus_write(3'd4, 16'h1357);
        @(negedge clk);
        bus_write(3'd4, 16'h2468);
        bus_read(3'd3, st);
        check("R11 second word held: txe", st[0], 1'b0);
        check("R11 first word busy", st[1], 1'b1);
        for (int i = 0; i < 40000; i++) begin
            bus_read(3'd3, st);
            if (st[0] && !st[1]) break;
        end
        bus_write(3'd2, 16'h0003);
        check("R11 second word reached slave", s_last, 16'h2468);
        bus_read(3'd3, st);
        check("R8 overrun set", st[3], 1'b1);
        bus_read(3'd5, rx);
        check("R8 new word overwrites", rx, 16'h5A5A);

        // R10: write-one-to-clear
        bus_write(3'd3, 16'h0000);
        bus_read(3'd3, st);
        check("R10 zero keeps overrun", st[3], 1'b1);
        check("R10 zero keeps done", st[4], 1'b1);
        bus_write(3'd3, 16'h0008);
        bus_read(3'd3, st);
        check("R10 one clears overrun", st[3], 1'b0);
        check("R10 done untouched by other bit", st[4], 1'b1);
        bus_write(3'd3, 16'h0010);
        bus_read(3'd3, st);
        check("R10 one clears done", st[4], 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule